// File: doc/BRIEF.md
# Banked Address Mapper with Fixed Common Window

This block sits between a 16-bit processor address bus and a larger RAM. It turns each logical address into a physical address that is one bank bit wider. The top 8K of logical space is a common window: it reaches the same physical memory whatever bank is selected. The other 56K are banked. Software picks the bank by writing to one I/O port. Code, the stack and shared data can therefore stay visible while the lower space is switched.

The mapping is chosen at build time:

- **OR-forcing mode** (the default) drives the upper physical bits to all ones inside the common window. It copies the bank and the window bits through everywhere else. This is cheap, but it leaves one 8K block of physical RAM that can never be reached.
- **Adder mode** packs the banks end to end at 56K strides and places the common window directly after the last bank. The physical RAM in use is then one gap-free range.

Two further build options are available:

- A low-page option pins logical 0x0000–0x00FF to physical 0x00000–0x000FF in every bank, so the vectors stay in one place.
- The physical address can be registered or combinational.

Top module: `bank_mapper`

## Requirements
- R1: Logical address bits 12..0 appear unchanged on physical bits 12..0 for every access outside the low page.
- R2: When logical bits 15..13 are all 1 (0xE000–0xFFFF), the OR mode drives physical bits 16..13 to all ones (0x1E000 + offset). The adder mode sends these addresses to physical block 14 (0x1C000 + offset). The bank bit has no effect in either mode.
- R3: In OR mode, outside the common window, physical bits 15..13 copy logical bits 15..13 and physical bit 16 is the bank bit. Bank 0 gives identity on 0x0000–0xDFFF, and bank 1 gives 0x10000–0x1DFFF.
- R4: In OR mode, no access ever yields a physical address in 0x0E000–0x0FFFF.
- R5: In adder mode, outside the common window, the physical address is bank × 0xE000 + logical address. Across both banks and the window, physical blocks 0..14 are all reached and block 15 is never reached.
- R6: With the low-page option, logical 0x0000–0x00FF gives the same physical address, whatever the bank bit.
- R7: The bank bit loads from io_data bit 0 at a clock edge where io_wr is 1 and io_addr equals BANK_PORT (default 0x40). It applies to accesses from the next cycle on. A write with another io_addr, or with io_wr at 0, leaves the bank unchanged.
- R8: Synchronous active-high reset clears the bank bit to 0. It also clears the registered physical address to 0.
- R9: Combinational output is the mapped address while mreq is 1 and zero while mreq is 0. Registered output captures the mapped address at each edge with mreq at 1 and holds it at edges with mreq at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | LA_W (16) | Logical address from the processor |
| mreq | input | 1 | Memory request qualifying cpu_addr |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | IO_AW (8) | I/O port address |
| io_data | input | BANK_W (1) | Bank value written on a matching I/O write |
| phys_addr | output | LA_W+BANK_W (17) | Physical RAM address |

## Verification
A bank bit held in the wrong state shows at the ports on the very next banked access outside the window and the low page. In OR mode it moves the address by 0x10000; in adder mode it moves it by 0xE000. This is seen in the same cycle for combinational output and one edge later for registered output. Every logical address is therefore swept in both banks, through an OR-mode instance and a registered adder-mode instance with the low page on. A wrong window or low-page decode shows as a single misplaced 8K block or 256-byte page. The bench also checks that the OR mode never lands in its hole and that the adder mode covers blocks 0..14 without a gap.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    typedef enum logic {
        MAP_OR  = 1'b0,
        MAP_ADD = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic common;   // address lies in the fixed top window
        logic lowpg;    // address lies in the pinned low page
    } win_t;

    // Physical block index (upper address bits) that the common window uses
    function automatic int common_block(map_mode_e m, int blk_w, int bank_w);
        if (m == MAP_ADD)
            return (2 ** bank_w) * ((2 ** blk_w) - 1);
        return (2 ** (blk_w + bank_w)) - 1;
    endfunction

endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
    parameter int              BANK_W    = 1,
    parameter int              IO_AW     = 8,
    parameter logic [IO_AW-1:0] BANK_PORT = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [BANK_W-1:0] io_data,
    output logic [BANK_W-1:0] bank
);

    logic hit;
    assign hit = io_wr && (io_addr == BANK_PORT);

    always_ff @(posedge clk) begin
        if (rst)
            bank <= '0;
        else if (hit)
            bank <= io_data;
    end

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import bank_map_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_OR,
    parameter int        LA_W   = 16,
    parameter int        OFF_W  = 13,
    parameter int        BANK_W = 1,
    parameter int        LOW_W  = 8,
    parameter bit        LOW_EN = 1'b0
) (
    input  logic [LA_W-1:0]        la,
    input  logic [BANK_W-1:0]      bank,
    output logic [LA_W+BANK_W-1:0] pa
);

    localparam int BLK_W = LA_W - OFF_W;
    localparam int HI_W  = BLK_W + BANK_W;
    localparam int PA_W  = LA_W + BANK_W;
    localparam int NBLK  = 2 ** BLK_W;
    localparam logic [HI_W-1:0] COMMON_HI = HI_W'(common_block(MODE, BLK_W, BANK_W));

    win_t             win;
    logic [BLK_W-1:0] blk;
    logic [HI_W-1:0]  hi;

    assign blk        = la[LA_W-1:OFF_W];
    assign win.common = &blk;

    generate
        if (LOW_EN) begin : g_low
            assign win.lowpg = (la[LA_W-1:LOW_W] == '0);
        end else begin : g_nolow
            assign win.lowpg = 1'b0;
        end
    endgenerate

    generate
        if (MODE == MAP_ADD) begin : g_add
            localparam logic [HI_W-1:0] STRIDE = HI_W'(NBLK - 1);
            always_comb begin
                if (win.common)
                    hi = COMMON_HI;
                else
                    hi = HI_W'(bank) * STRIDE + HI_W'(blk);
            end
        end else begin : g_or
            always_comb begin
                if (win.common)
                    hi = COMMON_HI;
                else
                    hi = {bank, blk};
            end
        end
    endgenerate

    always_comb begin
        if (win.lowpg)
            pa = PA_W'(la);
        else
            pa = {hi, la[OFF_W-1:0]};
    end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int PA_W    = 17,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mreq,
    input  logic [PA_W-1:0] d,
    output logic [PA_W-1:0] q
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (mreq)
                    q <= d;
            end
        end else begin : g_comb
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            always_comb q = mreq ? d : '0;
        end
    endgenerate

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_map_pkg::*;
#(
    parameter map_mode_e        MODE      = MAP_OR,
    parameter int               LA_W      = 16,
    parameter int               OFF_W     = 13,
    parameter int               BANK_W    = 1,
    parameter int               IO_AW     = 8,
    parameter logic [IO_AW-1:0] BANK_PORT = 8'h40,
    parameter int               LOW_W     = 8,
    parameter bit               LOW_EN    = 1'b0,
    parameter bit               REG_OUT   = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LA_W-1:0]        cpu_addr,
    input  logic                   mreq,
    input  logic                   io_wr,
    input  logic [IO_AW-1:0]       io_addr,
    input  logic [BANK_W-1:0]      io_data,
    output logic [LA_W+BANK_W-1:0] phys_addr
);

    localparam int PA_W = LA_W + BANK_W;

    logic [BANK_W-1:0] bank;
    logic [PA_W-1:0]   mapped;

    bank_sel_reg #(
        .BANK_W   (BANK_W),
        .IO_AW    (IO_AW),
        .BANK_PORT(BANK_PORT)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .io_wr  (io_wr),
        .io_addr(io_addr),
        .io_data(io_data),
        .bank   (bank)
    );

    addr_xlate #(
        .MODE  (MODE),
        .LA_W  (LA_W),
        .OFF_W (OFF_W),
        .BANK_W(BANK_W),
        .LOW_W (LOW_W),
        .LOW_EN(LOW_EN)
    ) u_xlate (
        .la  (cpu_addr),
        .bank(bank),
        .pa  (mapped)
    );

    out_stage #(
        .PA_W   (PA_W),
        .REG_OUT(REG_OUT)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .mreq(mreq),
        .d   (mapped),
        .q   (phys_addr)
    );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bank_map_pkg::*;
#(
    parameter map_mode_e        MODE      = MAP_OR,
    parameter int               LA_W      = 16,
    parameter int               OFF_W     = 13,
    parameter int               BANK_W    = 1,
    parameter int               IO_AW     = 8,
    parameter logic [IO_AW-1:0] BANK_PORT = 8'h40,
    parameter int               LOW_W     = 8,
    parameter bit               LOW_EN    = 1'b0,
    parameter bit               REG_OUT   = 1'b1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [LA_W-1:0]        cpu_addr,
    input logic                   mreq,
    input logic                   io_wr,
    input logic [IO_AW-1:0]       io_addr,
    input logic [LA_W+BANK_W-1:0] phys_addr,
    input logic [BANK_W-1:0]      bank
);

    localparam int BLK_W = LA_W - OFF_W;
    localparam int HI_W  = BLK_W + BANK_W;
    localparam int PA_W  = LA_W + BANK_W;
    localparam logic [HI_W-1:0] COMMON_HI = HI_W'(common_block(MODE, BLK_W, BANK_W));

    logic in_win;
    logic in_low;
    assign in_win = &cpu_addr[LA_W-1:OFF_W];
    assign in_low = LOW_EN && (cpu_addr[LA_W-1:LOW_W] == '0);

    generate
        if (REG_OUT) begin : g_reg
            assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
                mreq && !in_low |=> phys_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0]));
            assert_common_top_R2: assert property (@(posedge clk) disable iff (rst)
                mreq && in_win |=> phys_addr[PA_W-1:OFF_W] == COMMON_HI);
            assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !mreq |=> $stable(phys_addr));
        end else begin : g_comb
            assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
                mreq && !in_low |-> phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);
            assert_common_top_R2: assert property (@(posedge clk) disable iff (rst)
                mreq && in_win |-> phys_addr[PA_W-1:OFF_W] == COMMON_HI);
            assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
                !mreq |-> phys_addr == '0);
        end
    endgenerate

    // R4: in OR mode a top-of-bank block may only appear with all bank bits set
    assert_no_hole_R4: assert property (@(posedge clk) disable iff (rst)
        (MODE == MAP_OR) && (phys_addr[OFF_W+BLK_W-1:OFF_W] == '1)
        |-> phys_addr[PA_W-1:OFF_W+BLK_W] == '1);

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == BANK_PORT) |=> $stable(bank));

    logic rst_q = 1'b0;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q)
            assert_bank_reset_R8: assert (bank == '0)
                else $error("bank not cleared by reset");
    end

endmodule

bind bank_mapper bank_mapper_chk #(
    .MODE     (MODE),
    .LA_W     (LA_W),
    .OFF_W    (OFF_W),
    .BANK_W   (BANK_W),
    .IO_AW    (IO_AW),
    .BANK_PORT(BANK_PORT),
    .LOW_W    (LOW_W),
    .LOW_EN   (LOW_EN),
    .REG_OUT  (REG_OUT)
) u_chk (.*);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;
    import bank_map_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        mreq = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [0:0]  io_data = '0;
    logic [16:0] pa_or;
    logic [16:0] pa_add;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] seen_blk = '0;

    always #2.5 clk = ~clk;

    // OR-forcing, combinational output, no low page
    bank_mapper #(.MODE(MAP_OR), .LOW_EN(1'b0), .REG_OUT(1'b0)) u_bank_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mreq(mreq), .io_wr(io_wr),
        .io_addr(io_addr), .io_data(io_data), .phys_addr(pa_or));

    // Adder mode, registered output, low page pinned
    bank_mapper #(.MODE(MAP_ADD), .LOW_EN(1'b1), .REG_OUT(1'b1)) u_bank_mapper_add (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .mreq(mreq), .io_wr(io_wr),
        .io_addr(io_addr), .io_data(io_data), .phys_addr(pa_add));

    task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_or(int la, int b);
        if (la >= 32'hE000) return 17'(32'h1E000 + (la & 32'h1FFF));
        return 17'(b * 32'h10000 + la);
    endfunction

    function automatic logic [16:0] exp_add(int la, int b);
        if (la < 32'h100)   return 17'(la);
        if (la >= 32'hE000) return 17'(32'h1C000 + (la & 32'h1FFF));
        return 17'(b * 32'hE000 + la);
    endfunction

    task automatic bank_write(logic [7:0] port, logic wr, logic val);
        @(negedge clk);
        io_addr = port; io_wr = wr; io_data = val;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic sweep(int b);
        for (int la = 0; la < 65536; la++) begin
            @(negedge clk);
            cpu_addr = 16'(la); mreq = 1'b1;
            #1;
            chk(la >= 32'hE000 ? "R2 R1 or" : "R3 R1 or", pa_or, exp_or(la, b));
            if (pa_or >= 17'h0E000 && pa_or <= 17'h0FFFF)
                chk("R4 hole reached", pa_or, 17'h0);
            @(posedge clk);
            #1;
            chk(la < 32'h100 ? "R6 low page" : (la >= 32'hE000 ? "R2 add" : "R5 add"),
                pa_add, exp_add(la, b));
            seen_blk[pa_add[16:13]] = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 registered out cleared", pa_add, 17'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 comb idle zero", pa_or, 17'h0);

        // reset bank is 0
        @(negedge clk);
        cpu_addr = 16'h2345; mreq = 1'b1;
        #1;
        chk("R8 bank 0 after reset (or)", pa_or, 17'h02345);
        @(posedge clk); #1;
        chk("R8 bank 0 after reset (add)", pa_add, 17'h02345);

        // registered hold while mreq low
        @(negedge clk);
        cpu_addr = 16'h5000; mreq = 1'b0;
        #1;
        chk("R9 comb zero when idle", pa_or, 17'h0);
        @(posedge clk); #1;
        chk("R9 registered hold", pa_add, 17'h02345);

        // bank write through the port
        bank_write(8'h40, 1'b1, 1'b1);
        cpu_addr = 16'h1234; mreq = 1'b1;
        #1;
        chk("R7 bank set via port (or)", pa_or, 17'h11234);
        @(posedge clk); #1;
        chk("R7 bank set via port (add)", pa_add, 17'h0F234);

        // writes that must be ignored
        bank_write(8'h41, 1'b1, 1'b0);
        cpu_addr = 16'h1234;
        #1;
        chk("R7 other port ignored", pa_or, 17'h11234);
        bank_write(8'h40, 1'b0, 1'b0);
        #1;
        chk("R7 no strobe ignored", pa_or, 17'h11234);

        // back to bank 0 and sweep both banks
        bank_write(8'h40, 1'b1, 1'b0);
        #1;
        chk("R7 bank cleared via port", pa_or, 17'h01234);
        sweep(0);
        bank_write(8'h40, 1'b1, 1'b1);
        sweep(1);

        chk("R5 adder blocks contiguous", {1'b0, seen_blk}, 17'h07FFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5ns * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule